// File: doc/BRIEF.md
# Registered Single-Port Memory with Data Pass-Through

This block is a synchronous static memory with one clock and separate input and output data buses. Every input is captured in a register on the rising clock edge: the address, the write data, the write strobe, the array-enable strobe and the drive strobe. The block acts on those captured values at the following edge. At that edge the output register loads either the captured input word or the array word at the captured address. The array holds `2**ADDR_W` words of `WORD_W` bits. A full-size part would use a 19-bit address and 9-bit words. The defaults are kept small so that the model elaborates quickly.

The enable strobe never deselects the memory. It only gates writes into the array. A write strobe with the enable inactive is a pass-through cycle: the input word reaches the output, but the stored contents stay unchanged. The output never goes to high impedance. It is modelled as a data register plus a drive flag, and the drive flag falls only when the captured drive strobe is inactive. While the drive flag is low, the data register keeps its last value. All strobes are active low. A synchronous active-high reset clears the captured strobes to their inactive levels, so the output is not driven after reset.

Top module: `sync_pt_sram`

## Requirements
- R1: While reset is high and on the edge after it, `q_drive` is 0 and `q_data` is 0.
- R2: A cycle with `wr_n`=1 and `oe_n`=0 loads `q_data` with the stored word at the captured address on the next edge, and `q_drive` is 1. Latency is two edges from the input being presented to the output changing.
- R3: A cycle with `wr_n`, `ce_n` and `oe_n` all 0 stores `d_in` at the captured address and presents `d_in` on `q_data` at the next edge.
- R4: A cycle with `wr_n`=0, `ce_n`=1 and `oe_n`=0 presents `d_in` on `q_data` at the next edge and leaves the stored word at that address unchanged.
- R5: `ce_n`=1 never disables the output. A read with `ce_n`=1 and `oe_n`=0 returns the stored word with `q_drive`=1.
- R6: A cycle with `oe_n`=1 drives `q_drive` to 0 at the next edge, and `q_data` keeps its previous value.
- R7: A cycle with `wr_n`=0, `ce_n`=0 and `oe_n`=1 still stores `d_in` in the array, while the output is held.
- R8: A read of an address written in the immediately preceding cycle returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | ADDR_W | Word address |
| d_in | input | WORD_W | Write / pass-through data |
| wr_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Array write enable, active low; does not deselect |
| oe_n | input | 1 | Output drive strobe, active low |
| q_data | output | WORD_W | Registered output word |
| q_drive | output | 1 | High when the output would be driven |

## Verification
Two things can happen at the same edge: the array write and the output update with the pass-through word. The transparent write provokes this. It is judged at the output one edge later, and again by a read of the same address that follows immediately. A separate collision pairs pass-through with the enable inactive against stored data: the bench first writes a known word, then passes a different word through to the same address, and expects the output to show the new word while the read that follows returns the old one. A bench-side reference array and a one-stage prediction pipeline also check a long pseudo-random mix of all strobe combinations.

// File: rtl/sync_pt_sram_pkg.sv
package sync_pt_sram_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_WORD_W = 9;

    // captured strobes, stored active high
    typedef struct packed {
        logic wr;
        logic ce;
        logic oe;
    } strobe_t;

    typedef enum logic [1:0] {
        OSEL_HOLD = 2'd0,
        OSEL_READ = 2'd1,
        OSEL_PASS = 2'd2
    } osel_t;

    localparam strobe_t STROBE_IDLE = '{wr: 1'b0, ce: 1'b0, oe: 1'b0};

    function automatic osel_t pick_output(input strobe_t s);
        if (!s.oe)     return OSEL_HOLD;
        else if (s.wr) return OSEL_PASS;
        else           return OSEL_READ;
    endfunction

    function automatic logic array_write(input strobe_t s);
        return s.wr & s.ce;
    endfunction

endpackage

// File: rtl/spsr_in_stage.sv
module spsr_in_stage
    import sync_pt_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [WORD_W-1:0] d_in,
    input  logic              wr_n,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [ADDR_W-1:0] a_cap,
    output logic [WORD_W-1:0] d_cap,
    output strobe_t           s_cap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_cap <= '0;
            d_cap <= '0;
            s_cap <= STROBE_IDLE;
        end else begin
            a_cap    <= a_in;
            d_cap    <= d_in;
            s_cap.wr <= ~wr_n;
            s_cap.ce <= ~ce_n;
            s_cap.oe <= ~oe_n;
        end
    end

endmodule

// File: rtl/spsr_array.sv
module spsr_array
    import sync_pt_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/spsr_out_stage.sv
module spsr_out_stage
    import sync_pt_sram_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  osel_t             sel,
    input  logic [WORD_W-1:0] pass_word,
    input  logic [WORD_W-1:0] read_word,
    output logic [WORD_W-1:0] q_data,
    output logic              q_drive
);

    logic [WORD_W-1:0] next_word;

    always_comb begin
        unique case (sel)
            OSEL_PASS: next_word = pass_word;
            OSEL_READ: next_word = read_word;
            default:   next_word = q_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data  <= '0;
            q_drive <= 1'b0;
        end else begin
            q_data  <= next_word;
            q_drive <= (sel != OSEL_HOLD);
        end
    end

endmodule

// File: rtl/sync_pt_sram.sv
module sync_pt_sram
    import sync_pt_sram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [WORD_W-1:0] d_in,
    input  logic              wr_n,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] q_data,
    output logic              q_drive
);

    logic [ADDR_W-1:0] a_cap;
    logic [WORD_W-1:0] d_cap;
    strobe_t           s_cap;
    logic [WORD_W-1:0] rd_word;
    logic              arr_we;
    osel_t             osel;

    spsr_in_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_in (
        .clk   (clk),
        .rst   (rst),
        .a_in  (a_in),
        .d_in  (d_in),
        .wr_n  (wr_n),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .a_cap (a_cap),
        .d_cap (d_cap),
        .s_cap (s_cap)
    );

    assign arr_we = array_write(s_cap);
    assign osel   = pick_output(s_cap);

    spsr_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (arr_we),
        .addr  (a_cap),
        .wdata (d_cap),
        .rdata (rd_word)
    );

    spsr_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .sel       (osel),
        .pass_word (d_cap),
        .read_word (rd_word),
        .q_data    (q_data),
        .q_drive   (q_drive)
    );

endmodule

// File: rtl/spsr_checker.sv
module spsr_checker #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] a_in,
    input logic [WORD_W-1:0] d_in,
    input logic              wr_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [WORD_W-1:0] q_data,
    input logic              q_drive
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!q_drive && q_data == '0)); // R1

    AST_DRIVE_TRACKS_OE: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (q_drive == !$past(oe_n, 2))); // R2

    AST_PASS_WORD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(wr_n, 2) && !$past(oe_n, 2)) |-> (q_data == $past(d_in, 2))); // R4

    AST_CE_NO_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(ce_n, 2) && !$past(oe_n, 2)) |-> q_drive); // R5

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(oe_n, 2)) |-> $stable(q_data)); // R6

endmodule

bind sync_pt_sram spsr_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .d_in    (d_in),
    .wr_n    (wr_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .q_data  (q_data),
    .q_drive (q_drive)
);

// File: tb/sync_pt_sram_test.sv
module sync_pt_sram_test;

    localparam int AW    = 6;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] a_in = '0;
    logic [DW-1:0] d_in = '0;
    logic          wr_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] q_data;
    logic          q_drive;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] pend_d = '0;
    logic          pend_v = 1'b0;
    logic [DW-1:0] exp_d  = '0;
    logic          exp_v  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_pt_sram #(.ADDR_W(AW), .WORD_W(DW)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .d_in(d_in),
        .wr_n(wr_n), .ce_n(ce_n), .oe_n(oe_n),
        .q_data(q_data), .q_drive(q_drive)
    );

    task automatic check(input string tag, input logic [DW-1:0] ed, input logic ev);
        n_checks++;
        if (q_data !== ed || q_drive !== ev) begin
            n_errors++;
            $display("FAIL %s: q_data=%h q_drive=%b expected q_data=%h q_drive=%b",
                     tag, q_data, q_drive, ed, ev);
        end
    endtask

    // one cycle from a falling edge to the next; predicts the output of this op
    task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic w, input logic c, input logic o);
        logic [DW-1:0] pd;
        logic          pv;
        a_in = a; d_in = d; wr_n = w; ce_n = c; oe_n = o;
        if (o)       begin pd = pend_d;    pv = 1'b0; end
        else if (!w) begin pd = d;         pv = 1'b1; end
        else         begin pd = ref_mem[a]; pv = 1'b1; end
        if (!w && !c) ref_mem[a] = d;
        @(posedge clk);
        @(negedge clk);
        exp_d  = pend_d;
        exp_v  = pend_v;
        pend_d = pd;
        pend_v = pv;
    endtask

    task automatic idle();
        step('0, '0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", '0, 1'b0);
        rst = 1'b0;
        a_in = '0; wr_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", '0, 1'b0);
        pend_d = '0; pend_v = 1'b0;
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) step(AW'(i), DW'(i * 7 + 3), 1'b0, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_read();
        step(AW'(5), '0, 1'b1, 1'b0, 1'b0);
        step(AW'(9), '0, 1'b1, 1'b0, 1'b0);
        check("R2 read addr5", DW'(5 * 7 + 3), 1'b1);
        idle();
        check("R2 read addr9", DW'(9 * 7 + 3), 1'b1);
    endtask

    task automatic t_transparent();
        step(AW'(12), 9'h1A5, 1'b0, 1'b0, 1'b0);
        step(AW'(12), '0, 1'b1, 1'b0, 1'b0);
        check("R3 transparent write output", 9'h1A5, 1'b1);
        idle();
        check("R8 read right after write", 9'h1A5, 1'b1);
    endtask

    task automatic t_passthru();
        step(AW'(20), 9'h0F0, 1'b0, 1'b1, 1'b0);
        step(AW'(20), '0, 1'b1, 1'b0, 1'b0);
        check("R4 pass-through output", 9'h0F0, 1'b1);
        idle();
        check("R4 array unchanged", DW'(20 * 7 + 3), 1'b1);
    endtask

    task automatic t_ce_read();
        step(AW'(33), '0, 1'b1, 1'b1, 1'b0);
        idle();
        check("R5 read with ce_n high", DW'(33 * 7 + 3), 1'b1);
    endtask

    task automatic t_disable();
        logic [DW-1:0] held;
        step(AW'(40), '0, 1'b1, 1'b0, 1'b0);
        step(AW'(41), '0, 1'b1, 1'b0, 1'b1);
        held = DW'(40 * 7 + 3);
        check("R2 read before disable", held, 1'b1);
        step(AW'(42), 9'h155, 1'b0, 1'b1, 1'b1);
        check("R6 disabled hold", held, 1'b0);
        step(AW'(43), '0, 1'b1, 1'b0, 1'b0);
        check("R6 disabled pass-through held", held, 1'b0);
        idle();
        check("R6 drive restored", DW'(43 * 7 + 3), 1'b1);
    endtask

    task automatic t_hidden_write();
        step(AW'(50), 9'h0AA, 1'b0, 1'b0, 1'b1);
        step(AW'(50), '0, 1'b1, 1'b1, 1'b0);
        check("R7 write with output off", exp_d, 1'b0);
        idle();
        check("R7 stored while off", 9'h0AA, 1'b1);
    endtask

    task automatic t_mix();
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(AW'(lf[5:0] & 6'h0F), DW'(lf[15:7]), lf[0] & lf[6], lf[1], lf[2] & lf[3]);
            check("R2/R3/R4 mixed traffic", exp_d, exp_v);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fill();
        t_read();
        t_transparent();
        t_passthru();
        t_ce_read();
        t_disable();
        t_hidden_write();
        t_mix();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule